// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the pin-facing half of a general purpose I/O controller. It splits `NUM_PINS` lines into banks of eight and gives each bank two 8-bit registers: one holds the value the pins drive, and one holds each pin's direction. A 32-bit register bus reads and writes these registers. Each write takes effect at the clock edge that accepts it. Each read answers one cycle after it is issued. The block drives a per-pin output enable and output value. It also samples the pad inputs through a two-flop synchronizer.

Line n belongs to bank n/8 and uses bit n%8 of that bank's registers. Bank b sits at base address (b+1)*8, with the data register at +0 and the direction register at +4. The address window 0x90 to 0x9F belongs to a neighbouring interrupt unit. Any base that would land at or above 0x90 is moved up by 0x10, so no bank overlaps that window. Software switches a pin to output in two steps: it first writes the value into the data register while the pin is still an input, then it clears the direction bit. The data register therefore keeps whatever is written to it, whatever the pin's direction.

The read path has a two-state machine. `RD_IDLE` means no response is pending. `RD_RESP` means read data is on `bus_rdata` with `bus_rvalid` high. The transition `IDLE->RESP` fires on a read request. `RESP->RESP` fires on a read request issued in the cycle the previous response is shown. `RESP->IDLE` fires when no read is requested.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset, every direction bit is 1 and every data bit is 0. As a result, `pin_oe` and `pin_out` are all zero, and a direction register reads 0xFF (or fewer ones in a partial bank).
- R2: Line n is bit n%8 of bank n/8. Bank b's data register is at (b+1)*8 and its direction register is at (b+1)*8+4.
- R3: A bank base that computes to 0x90 or more is moved up by 0x10. Addresses 0x90 to 0x9F read as zero, and writes to them change no register and no pin.
- R4: A direction bit of 1 makes the pin an input (`pin_oe` low). A direction bit of 0 sets `pin_oe` high and drives the stored data bit on `pin_out`, starting in the cycle after the accepting edge.
- R5: A data register read returns, bit by bit, the synchronized pad input where the direction bit is 1 and the stored data bit where it is 0. A change on a pad reaches the sampled value after two clock edges.
- R6: The data register keeps a value written while the pin is an input. Clearing the direction bit afterwards drives that value.
- R7: Bits of the last bank that stand for lines at or beyond `NUM_PINS` read as 0 in both registers and ignore writes.
- R8: Unmapped addresses read as zero, and writes to them have no effect. These are 0x00, 0x04, any address with bits [1:0] not zero, and any address past the last bank.
- R9: A read issued at a clock edge gives `bus_rvalid` high with its data in the following cycle. Back-to-back reads each get their own response. Bits 31:8 of `bus_wdata` are ignored, and bits 31:8 of `bus_rdata` are zero.
- R10: A direction register reads back the value last written to its implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wen | input | 1 | Write request, one word per cycle |
| bus_ren | input | 1 | Read request, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data, bits 7:0 used |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | NUM_PINS | Asynchronous pad inputs |
| pin_oe | output | NUM_PINS | Per-pin output enable (1 = drive) |
| pin_out | output | NUM_PINS | Per-pin output value |

## Verification
A register write shows on `pin_oe` and `pin_out` in the cycle after the edge that accepts it. The bench drives every request at a falling edge and checks the pins at the next falling edge. A read response is due exactly one cycle after the request. The driver queues each expected word as it issues the read, and the monitor pops it at the falling edge on which `bus_rvalid` shows. An unexpected or missing response therefore appears as a mismatch or as a leftover entry. A pad change needs two edges to pass the synchronizer, so the bench waits three cycles after moving `pin_in` before it reads the data register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int LINES_PER_BANK = 8;
    localparam int WIN_LO         = 'h90;
    localparam int WIN_SKIP       = 'h10;
    localparam int DIR_OFFSET     = 4;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    // Base byte address of a bank, stepping over the interrupt window.
    function automatic int bank_base(input int b);
        int r;
        r = (b + 1) * LINES_PER_BANK;
        if (r >= WIN_LO) r = r + WIN_SKIP;
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 19,
    parameter int BANK_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              sel_dir,
    output logic [BANK_W-1:0] bank_idx
);
    logic [ADDR_W-1:0] word_base;

    assign word_base = {addr[ADDR_W-1:3], 3'b000};
    assign sel_dir   = addr[2];

    always_comb begin
        hit      = 1'b0;
        bank_idx = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr[1:0] == 2'b00 && word_base == ADDR_W'(bank_base(b))) begin
                hit      = 1'b1;
                bank_idx = BANK_W'(b);
            end
        end
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [7:0]       wdata,
    input  logic [LINES-1:0] pad_sync,
    output logic [LINES-1:0] data_q,
    output logic [LINES-1:0] dir_q,
    output logic [7:0]       rd_data,
    output logic [7:0]       rd_dir
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '1;
        end else begin
            if (wr_data) data_q <= wdata[LINES-1:0];
            if (wr_dir)  dir_q  <= wdata[LINES-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_dir  = '0;
        rd_data[LINES-1:0] = (dir_q & pad_sync) | (~dir_q & data_q);
        rd_dir[LINES-1:0]  = dir_q;
    end
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 148,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wen,
    input  logic                bus_ren,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    localparam int NUM_BANKS = (NUM_PINS + LINES_PER_BANK - 1) / LINES_PER_BANK;
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_PINS-1:0] pad_sync;
    logic                hit;
    logic                sel_dir;
    logic [BANK_W-1:0]   bank_idx;
    logic [7:0]          bank_rd_data [NUM_BANKS];
    logic [7:0]          bank_rd_dir  [NUM_BANKS];
    logic [7:0]          rd_word;
    logic [31:0]         rdata_q;
    logic                unused_wdata_hi;
    rd_state_e           state_q, state_d;

    assign unused_wdata_hi = ^bus_wdata[31:8];

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pad_sync)
    );

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .sel_dir  (sel_dir),
        .bank_idx (bank_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LN = ((NUM_PINS - b * LINES_PER_BANK) >= LINES_PER_BANK)
                            ? LINES_PER_BANK : (NUM_PINS - b * LINES_PER_BANK);
        logic          sel;
        logic [LN-1:0] data_q;
        logic [LN-1:0] dir_q;

        assign sel = bus_wen && hit && (bank_idx == BANK_W'(b));

        gpio_port_bank #(.LINES(LN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_data  (sel && !sel_dir),
            .wr_dir   (sel && sel_dir),
            .wdata    (bus_wdata[7:0]),
            .pad_sync (pad_sync[b*LINES_PER_BANK +: LN]),
            .data_q   (data_q),
            .dir_q    (dir_q),
            .rd_data  (bank_rd_data[b]),
            .rd_dir   (bank_rd_dir[b])
        );

        assign pin_oe[b*LINES_PER_BANK +: LN]  = ~dir_q;
        assign pin_out[b*LINES_PER_BANK +: LN] = data_q;
    end

    always_comb begin
        rd_word = '0;
        if (hit) rd_word = sel_dir ? bank_rd_dir[bank_idx] : bank_rd_data[bank_idx];
    end

    // Read response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_ren) rdata_q <= {24'd0, rd_word};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (bus_ren) state_d = RD_RESP;
            RD_RESP: if (!bus_ren) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // Outputs of the read path
    always_comb begin
        bus_rvalid = (state_q == RD_RESP);
        bus_rdata  = bus_rvalid ? rdata_q : 32'd0;
    end
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk #(
    parameter int NUM_PINS = 148,
    parameter int ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wen,
    input logic                bus_ren,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic                bus_rvalid,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out
);
    logic in_window;
    logic low_hole;

    assign in_window = (bus_addr >= ADDR_W'('h90)) && (bus_addr <= ADDR_W'('h9F));
    assign low_hole  = (bus_addr < ADDR_W'(8));

    assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ren |=> bus_rvalid);

    assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> !bus_rvalid);

    assert_rdata_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:8] == 24'd0));

    assert_window_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && in_window) |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_low_hole_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && low_hole) |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_pins_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wen |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wen    (bus_wen),
    .bus_ren    (bus_ren),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
);

// File: tb/gpio_bank_regfile_bench.sv
`timescale 1ns/1ps
module gpio_bank_regfile_bench;
    localparam int NP = 148;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wen = 1'b0;
    logic          bus_ren = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] pin_out;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    gpio_bank_regfile #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_bank_regfile (
        .clk (clk), .rst_n (rst_n), .bus_wen (bus_wen), .bus_ren (bus_ren),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid), .pin_in (pin_in), .pin_oe (pin_oe), .pin_out (pin_out)
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_ren = 1'b1; bus_addr = AW'(addr);
        @(negedge clk);
        bus_ren = 1'b0;
    endtask

    // Monitor: pops one expected word per response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response", 256'(bus_rdata), 256'hDEAD);
            end else begin
                check(tag_q.pop_front(), 256'(bus_rdata), 256'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NP-1:0] snap_oe, snap_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pin_oe", 256'(pin_oe), 256'd0);
        check("R1 reset pin_out", 256'(pin_out), 256'd0);
        rd('h0C, 32'hFF, "R1 R10 bank0 dir after reset");
        rd('hAC, 32'h0F, "R1 R7 partial bank dir after reset");

        // R5: input read through the synchronizer
        pin_in[7:0] = 8'hA5;
        repeat (3) @(negedge clk);
        rd('h08, 32'hA5, "R5 input pins read pad value");

        // R6: data written while input is kept, then driven
        wr('h08, 32'h3C);
        check("R6 still input after data write", 256'(pin_oe[7:0]), 256'h00);
        rd('h08, 32'hA5, "R6 input read ignores stored data");
        wr('h0C, 32'h0F);
        check("R4 oe follows cleared dir bits", 256'(pin_oe[7:0]), 256'hF0);
        check("R6 stored data driven", 256'(pin_out[7:0]), 256'h3C);
        rd('h08, 32'h35, "R5 mixed direction read");
        rd('h0C, 32'h0F, "R10 dir readback");

        // R2, R9: bank1 at 0x10/0x14, upper write bits ignored
        wr('h10, 32'hFFFF_FF81);
        wr('h14, 32'hFFFF_FF00);
        check("R2 bank1 oe", 256'(pin_oe[15:8]), 256'hFF);
        check("R2 R9 bank1 out", 256'(pin_out[15:8]), 256'h81);
        rd('h10, 32'h81, "R9 upper read bits zero");

        // R2: last bank below the window
        wr('h88, 32'h5A);
        wr('h8C, 32'h00);
        check("R2 bank16 out", 256'(pin_out[135:128]), 256'h5A);

        // R3: window ignored
        snap_oe = pin_oe; snap_out = pin_out;
        wr('h90, 32'hFF); wr('h94, 32'h00); wr('h98, 32'hFF); wr('h9C, 32'h00);
        check("R3 window write oe", 256'(pin_oe), 256'(snap_oe));
        check("R3 window write out", 256'(pin_out), 256'(snap_out));
        rd('h90, 32'h0, "R3 window read zero");
        rd('h9C, 32'h0, "R3 window read zero top");

        // R3: bank17 moved to 0xA0
        wr('hA0, 32'hC3);
        wr('hA4, 32'h00);
        check("R3 bank17 out", 256'(pin_out[143:136]), 256'hC3);
        check("R3 bank17 oe", 256'(pin_oe[143:136]), 256'hFF);

        // R7: partial bank at 0xA8
        pin_in[147:144] = 4'b0100;
        wr('hA8, 32'hFF);
        wr('hAC, 32'hFC);
        check("R7 partial bank oe", 256'(pin_oe[147:144]), 256'h3);
        check("R7 partial bank out", 256'(pin_out[147:144]), 256'hF);
        rd('hAC, 32'h0C, "R7 unimplemented dir bits read zero");
        rd('hA8, 32'h07, "R7 unimplemented data bits read zero");

        // R8: unmapped
        snap_oe = pin_oe; snap_out = pin_out;
        wr('h00, 32'hFF); wr('h04, 32'h00); wr('hB0, 32'h00); wr('hB4, 32'h00); wr('h0A, 32'h00);
        check("R8 unmapped write oe", 256'(pin_oe), 256'(snap_oe));
        check("R8 unmapped write out", 256'(pin_out), 256'(snap_out));
        rd('h00, 32'h0, "R8 read 0x00");
        rd('hB4, 32'h0, "R8 read past last bank");
        rd('h0E, 32'h0, "R8 misaligned read");

        // R9: back-to-back reads
        @(negedge clk);
        exp_q.push_back(32'h81); tag_q.push_back("R9 back-to-back first");
        bus_ren = 1'b1; bus_addr = AW'('h10);
        @(negedge clk);
        exp_q.push_back(32'hFF); tag_q.push_back("R9 back-to-back second");
        bus_addr = AW'('h1C);
        @(negedge clk);
        bus_ren = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 no outstanding responses", 256'(exp_q.size()), 256'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule